// File: doc/BRIEF.md
# ALU Condition Flag Generator

This block is the arithmetic and logic stage of a 32-bit integer datapath. It is purely combinational. It takes a first operand and a second operand that has already passed through the barrel shifter, together with the shifter's carry-out. It also takes the current negative, zero, carry and overflow flags, a 4-bit operation code and a set-flags bit. From these it produces the operation result, the next value of the four flags, and a strobe that tells the register file whether the result should be written back.

Arithmetic operations share one adder. Subtract-class operations feed the adder with an inverted operand and a carry-in, so their carry output means "no borrow". Logical operations take their carry from the shifter and pass the overflow flag through unchanged. The three comparison operations always update the flags and never write a result. Any other supported operation changes the flags only when set-flags is high. The three operation codes that are not used change nothing.

Top module: `afg_core`

## Requirements
- R1: Operation codes are: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 reverse subtract-with-carry, 5 AND, 6 OR, 7 bit-clear, 8 move, 9 move-not, 10 test, 11 compare, 12 compare-negative. The flag vector is ordered {N, Z, C, V}, with N in bit 3 and V in bit 0.
- R2: Whenever the flags are updated, N equals bit 31 of the result and Z is 1 exactly when all 32 result bits are zero.
- R3: For add, add-with-carry and compare-negative, C is the carry out of bit 31 and V is the signed overflow of the sum. For add-with-carry, the sum includes the incoming C.
- R4: For subtract, compare, subtract-with-carry and reverse subtract-with-carry, C is 1 when the subtraction produces no borrow, and V is the signed overflow of the difference.
- R5: Subtract-with-carry yields first − second − (1 − C). Reverse subtract-with-carry yields second − first − (1 − C).
- R6: The logical results are as follows. AND gives a & b. OR gives a | b. Bit-clear gives a & ~b. Move gives b. Move-not gives ~b. Test evaluates a & b.
- R7: For AND, OR, bit-clear, move, move-not and test, an update sets C to the shifter carry-out and keeps V at its input value.
- R8: Test, compare and compare-negative update the flags whatever the set-flags bit is, and they hold write-enable low.
- R9: Operations 0 to 9 drive write-enable high. Their output flags equal the input flags when set-flags is 0.
- R10: Codes 13, 14 and 15 drive write-enable low, return a zero result, and pass all four flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Shifted second operand |
| shc_i | input | 1 | Carry-out of the shifter |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| opcode_i | input | 4 | Operation code |
| setf_i | input | 1 | Set-flags request |
| result_o | output | 32 | Operation result |
| flags_o | output | 4 | Next flags {N,Z,C,V} |
| wr_en_o | output | 1 | Result write-back enable |

## Verification
The block holds no state, so any fault in the decode or in the operand steering appears on the outputs for the same input vector. The result, the flags or the write strobe then differ from the reference at the first sample after the inputs settle. A wrong carry-in selection or a swapped operand shows up only on vectors that set the relevant flag or operand bit. For that reason the stimulus mixes every code, every flag combination and overflow corners with random operands.

// File: rtl/afg_pkg.sv
// Shared types for the condition flag generator: operation codes,
// flag bit positions and the decoded control word.
package afg_pkg;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_RSC = 4'd4,
        OP_AND = 4'd5,
        OP_ORR = 4'd6,
        OP_BIC = 4'd7,
        OP_MOV = 4'd8,
        OP_MVN = 4'd9,
        OP_TST = 4'd10,
        OP_CMP = 4'd11,
        OP_CMN = 4'd12
    } afg_op_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_FLAG = 2'd2
    } afg_cin_e;

    typedef enum logic [2:0] {
        LOP_AND = 3'd0,
        LOP_OR  = 3'd1,
        LOP_BIC = 3'd2,
        LOP_MOV = 3'd3,
        LOP_MVN = 3'd4
    } afg_lop_e;

    typedef struct packed {
        logic     valid;        // supported code
        logic     arith;        // result and C/V come from the adder
        logic     flags_always; // comparison class
        logic     swap;         // adder x takes the second operand
        logic     invert;       // adder y is inverted
        afg_cin_e cin;          // adder carry-in source
        afg_lop_e lop;          // logic function
    } afg_ctrl_t;

endpackage

// File: rtl/afg_decode.sv
// Operation decoder. It maps the 4-bit code onto the control word that
// steers the adder and the logic unit.
// Assumes: codes above the last defined operation are invalid.
module afg_decode
    import afg_pkg::*;
(
    input  logic [3:0] opcode_i,
    output afg_ctrl_t  ctrl_o
);

    // Purpose: translate the operation code into datapath controls.
    always_comb begin
        ctrl_o = '{valid: 1'b1, arith: 1'b0, flags_always: 1'b0, swap: 1'b0,
                   invert: 1'b0, cin: CIN_ZERO, lop: LOP_AND};
        case (opcode_i)
            OP_ADD: begin ctrl_o.arith = 1'b1; end
            OP_ADC: begin ctrl_o.arith = 1'b1; ctrl_o.cin = CIN_FLAG; end
            OP_SUB: begin ctrl_o.arith = 1'b1; ctrl_o.invert = 1'b1; ctrl_o.cin = CIN_ONE; end
            OP_SBC: begin ctrl_o.arith = 1'b1; ctrl_o.invert = 1'b1; ctrl_o.cin = CIN_FLAG; end
            OP_RSC: begin
                ctrl_o.arith  = 1'b1;
                ctrl_o.swap   = 1'b1;
                ctrl_o.invert = 1'b1;
                ctrl_o.cin    = CIN_FLAG;
            end
            OP_AND: ctrl_o.lop = LOP_AND;
            OP_ORR: ctrl_o.lop = LOP_OR;
            OP_BIC: ctrl_o.lop = LOP_BIC;
            OP_MOV: ctrl_o.lop = LOP_MOV;
            OP_MVN: ctrl_o.lop = LOP_MVN;
            OP_TST: begin ctrl_o.lop = LOP_AND; ctrl_o.flags_always = 1'b1; end
            OP_CMP: begin
                ctrl_o.arith        = 1'b1;
                ctrl_o.invert       = 1'b1;
                ctrl_o.cin          = CIN_ONE;
                ctrl_o.flags_always = 1'b1;
            end
            OP_CMN: begin ctrl_o.arith = 1'b1; ctrl_o.flags_always = 1'b1; end
            default: ctrl_o.valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/afg_arith.sv
// Single adder shared by every arithmetic operation. It returns the sum,
// the carry out of the top bit and the two's-complement overflow.
// Assumes: subtraction is presented as x + ~y + cin by the caller.
module afg_arith #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] full;

    // Purpose: form the three-input sum with one extra bit for carry.
    always_comb begin
        full   = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i};
        sum_o  = full[MSB:0];
        cout_o = full[WIDTH];
        ovf_o  = (x_i[MSB] == y_i[MSB]) && (full[MSB] != x_i[MSB]);
    end

endmodule

// File: rtl/afg_logic.sv
// Bitwise unit for AND, OR, bit-clear, move and move-not.
// Assumes: the second operand is already shifted.
module afg_logic
    import afg_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  afg_lop_e         lop_i,
    output logic [WIDTH-1:0] res_o
);

    // Purpose: select the requested bitwise function.
    always_comb begin
        case (lop_i)
            LOP_AND: res_o = a_i & b_i;
            LOP_OR:  res_o = a_i | b_i;
            LOP_BIC: res_o = a_i & ~b_i;
            LOP_MOV: res_o = b_i;
            LOP_MVN: res_o = ~b_i;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/afg_core.sv
// Top of the condition flag generator. It steers the operands into the
// adder or the logic unit, picks the result and forms the next flags
// and the write-back strobe.
// Assumes: combinational use; the caller registers the outputs.
module afg_core
    import afg_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             shc_i,
    input  logic [3:0]       flags_i,
    input  logic [3:0]       opcode_i,
    input  logic             setf_i,
    output logic [WIDTH-1:0] result_o,
    output logic [3:0]       flags_o,
    output logic             wr_en_o
);

    localparam int MSB = WIDTH - 1;

    afg_ctrl_t        ctrl;
    logic [WIDTH-1:0] add_x, add_y, y_raw, add_sum, log_res;
    logic             add_cin, add_cout, add_ovf, upd;

    afg_decode u_dec (.opcode_i(opcode_i), .ctrl_o(ctrl));

    // Purpose: order, invert and carry-in steering for the adder.
    always_comb begin
        add_x = ctrl.swap ? opb_i : opa_i;
        y_raw = ctrl.swap ? opa_i : opb_i;
        add_y = ctrl.invert ? ~y_raw : y_raw;
        case (ctrl.cin)
            CIN_ONE:  add_cin = 1'b1;
            CIN_FLAG: add_cin = flags_i[FLAG_C];
            default:  add_cin = 1'b0;
        endcase
    end

    afg_arith #(.WIDTH(WIDTH)) u_add (
        .x_i(add_x), .y_i(add_y), .cin_i(add_cin),
        .sum_o(add_sum), .cout_o(add_cout), .ovf_o(add_ovf)
    );

    afg_logic #(.WIDTH(WIDTH)) u_log (
        .a_i(opa_i), .b_i(opb_i), .lop_i(ctrl.lop), .res_o(log_res)
    );

    // Purpose: result select, flag update and write strobe.
    always_comb begin
        if (!ctrl.valid)     result_o = '0;
        else if (ctrl.arith) result_o = add_sum;
        else                 result_o = log_res;

        upd     = ctrl.valid && (ctrl.flags_always || setf_i);
        wr_en_o = ctrl.valid && !ctrl.flags_always;

        flags_o = flags_i;
        if (upd) begin
            flags_o[FLAG_N] = result_o[MSB];
            flags_o[FLAG_Z] = (result_o == '0);
            flags_o[FLAG_C] = ctrl.arith ? add_cout : shc_i;
            flags_o[FLAG_V] = ctrl.arith ? add_ovf : flags_i[FLAG_V];
        end
    end

endmodule

// File: rtl/afg_checker.sv
// Property checker for afg_core. It watches the ports only and is
// attached with bind. Assumes: inputs settle before they are observed.
module afg_checker #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic             shc_i,
    input logic [3:0]       flags_i,
    input logic [3:0]       opcode_i,
    input logic             setf_i,
    input logic [WIDTH-1:0] result_o,
    input logic [3:0]       flags_o,
    input logic             wr_en_o
);

    logic is_cmp, is_logic, is_bad, upd;

    // Purpose: classify the current code and decide whether flags may move.
    always_comb begin
        is_bad   = (opcode_i > 4'd12);
        is_cmp   = (opcode_i >= 4'd10) && !is_bad;
        is_logic = ((opcode_i >= 4'd5) && (opcode_i <= 4'd10));
        upd      = !is_bad && (is_cmp || setf_i);
    end

    // Purpose: port-level properties of the flag generator.
    always_comb begin
        AST_UNSUP_HOLD: assert (!is_bad || (!wr_en_o && flags_o == flags_i && result_o == '0)); // R10
        AST_CMP_NOWRITE: assert (!is_cmp || !wr_en_o); // R8
        AST_NOSET_HOLD: assert (is_cmp || is_bad || setf_i || (wr_en_o && flags_o == flags_i)); // R9
        AST_N_TRACKS_MSB: assert (!upd || flags_o[3] == result_o[WIDTH-1]); // R2
        AST_Z_TRACKS_ZERO: assert (!upd || flags_o[2] == (result_o == '0)); // R2
        AST_LOGIC_CV: assert (!(upd && is_logic) || (flags_o[1] == shc_i && flags_o[0] == flags_i[0])); // R7
    end

    logic unused_ok;
    assign unused_ok = ^{opa_i, opb_i};

endmodule

bind afg_core afg_checker #(.WIDTH(WIDTH)) u_chk (
    .opa_i(opa_i), .opb_i(opb_i), .shc_i(shc_i), .flags_i(flags_i),
    .opcode_i(opcode_i), .setf_i(setf_i), .result_o(result_o),
    .flags_o(flags_o), .wr_en_o(wr_en_o)
);

// File: tb/sim_afg_core.sv
module sim_afg_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opa, opb, res;
    logic        shc, setf, we;
    logic [3:0]  fin, fout, op;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    afg_core u0 (
        .opa_i(opa), .opb_i(opb), .shc_i(shc), .flags_i(fin),
        .opcode_i(op), .setf_i(setf), .result_o(res),
        .flags_o(fout), .wr_en_o(we)
    );

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd0, 4'd1, 4'd12: return "R3";
            4'd2, 4'd11:       return "R4";
            4'd3, 4'd4:        return "R5";
            4'd13, 4'd14, 4'd15: return "R10";
            default:           return "R6";
        endcase
    endfunction

    // Behavioural reference built on 64-bit integer arithmetic.
    task automatic model(input logic [3:0] o, input logic [31:0] a, b,
                         input logic sc, input logic [3:0] f, input logic sf,
                         output logic [31:0] r, output logic [3:0] fo, output logic w);
        longint ua = longint'(a), ub = longint'(b);
        longint sa = longint'($signed(a)), sb = longint'($signed(b));
        longint full = 0, sfull = 0;
        longint bin = f[1] ? 0 : 1;
        longint cin = f[1] ? 1 : 0;
        bit arith = 1'b1, nc = 1'b0, nv, always_f = (o >= 10 && o <= 12);
        case (o)
            4'd0, 4'd12: begin full = ua + ub; sfull = sa + sb; nc = full[32]; end
            4'd1: begin full = ua + ub + cin; sfull = sa + sb + cin; nc = full[32]; end
            4'd2, 4'd11: begin full = ua - ub; sfull = sa - sb; nc = (full >= 0); end
            4'd3: begin full = ua - ub - bin; sfull = sa - sb - bin; nc = (full >= 0); end
            4'd4: begin full = ub - ua - bin; sfull = sb - sa - bin; nc = (full >= 0); end
            4'd5, 4'd10: begin arith = 0; full = longint'(a & b); end
            4'd6: begin arith = 0; full = longint'(a | b); end
            4'd7: begin arith = 0; full = longint'(a & ~b); end
            4'd8: begin arith = 0; full = ub; end
            4'd9: begin arith = 0; full = longint'(~b); end
            default: begin r = 0; fo = f; w = 0; return; end
        endcase
        r  = full[31:0];
        nv = (sfull > 64'sd2147483647) || (sfull < -64'sd2147483648);
        w  = !always_f;
        fo = f;
        if (always_f || sf)
            fo = {r[31], r == 0, arith ? nc : sc, arith ? nv : f[0]};
    endtask

    task automatic apply(input logic [3:0] o, input logic [31:0] a, b,
                         input logic sc, input logic [3:0] f, input logic sf);
        logic [31:0] er; logic [3:0] ef; logic ew;
        @(negedge clk);
        op = o; opa = a; opb = b; shc = sc; fin = f; setf = sf;
        model(o, a, b, sc, f, sf, er, ef, ew);
        #5;
        n_chk++;
        if (res !== er) begin
            n_err++;
            $display("FAIL %s result op=%0d got=%h exp=%h", tag_of(o), o, res, er);
        end
        n_chk++;
        if (fout !== ef) begin
            n_err++;
            $display("FAIL %s/R2/R7 flags op=%0d setf=%0b got=%b exp=%b",
                     tag_of(o), o, sf, fout, ef);
        end
        n_chk++;
        if (we !== ew) begin
            n_err++;
            $display("FAIL R8/R9/R10 wr_en op=%0d got=%b exp=%b", o, we, ew);
        end
    endtask

    initial begin
        op = 0; opa = 0; opb = 0; shc = 0; fin = 0; setf = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle vector: add of zeros without set-flags (R1, R9)
        apply(4'd0, 0, 0, 0, 4'b0000, 0);
        // R3 corners
        apply(4'd0, 32'h7FFFFFFF, 32'h1, 0, 4'b0000, 1);
        apply(4'd0, 32'hFFFFFFFF, 32'h1, 0, 4'b0000, 1);
        apply(4'd1, 32'h7FFFFFFF, 32'h0, 0, 4'b0010, 1);
        apply(4'd1, 32'hFFFFFFFF, 32'h0, 0, 4'b0010, 1);
        apply(4'd12, 32'h80000000, 32'h80000000, 0, 4'b0000, 0);
        // R4 corners
        apply(4'd2, 32'h0, 32'h1, 0, 4'b0000, 1);
        apply(4'd2, 32'h5, 32'h5, 0, 4'b0000, 1);
        apply(4'd2, 32'h80000000, 32'h1, 0, 4'b0000, 1);
        apply(4'd11, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 4'b0000, 0);
        // R5 carry-in handling
        apply(4'd3, 32'h10, 32'h10, 0, 4'b0000, 1);
        apply(4'd3, 32'h10, 32'h10, 0, 4'b0010, 1);
        apply(4'd4, 32'h3, 32'h9, 0, 4'b0000, 1);
        apply(4'd4, 32'h9, 32'h9, 0, 4'b0010, 1);
        // R6 / R7 logical, V held in both states
        apply(4'd7, 32'hFFFF00FF, 32'h0F0F0F0F, 1, 4'b0001, 1);
        apply(4'd9, 32'h0, 32'hFFFFFFFF, 0, 4'b1111, 1);
        apply(4'd10, 32'hF0, 32'h0F, 1, 4'b0000, 0);
        apply(4'd8, 32'h0, 32'h80000000, 1, 4'b0001, 0);
        // R10 unused codes
        for (int c = 13; c < 16; c++)
            apply(4'(c), 32'h12345678, 32'h9ABCDEF0, 1, 4'b1010, 1);
        // Mixed sweep
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (i % 7 == 0) ra = {ra[31], 31'h7FFFFFFF};
            if (i % 11 == 0) rb = ra;
            apply(4'(i % 16), ra, rb, 1'($urandom), 4'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule